// File: doc/BRIEF.md
# Dual-Channel Interval Timer Prescaler

This block is a time base for periodic interrupts. A 15-bit binary divider counts cycles of a slow subsystem clock. Two channels, A and B, each pick one divider stage through their own multiplexer. Each channel emits a one-cycle request pulse whenever its chosen stage rises.

Software programs the block over a small internal I/O bus at one address, `0xF`, which holds two registers. The primary register carries a tap code and a bit that names the channel the code is meant for. Each channel keeps the code it receives in its own buffer, so reprogramming one channel never changes the rate of the other.

The auxiliary register holds a mask bit and a priority-level bit for each channel. The level bits go straight to the outputs, and arbitration between the two levels happens elsewhere. While both channels are masked, the divider is held at zero. The first request after an unmask therefore comes at a fixed, known time.

Top module: `tick_prescaler`

## Requirements
- R1: After reset, both request outputs are low, both level outputs are low, and both channels are masked. The divider is held at zero, so no request appears until a channel is unmasked.
- R2: A write whose address is not the block address (default `0xF`) changes no code, mask or level, whether it targets the primary or the auxiliary register.
- R3: A primary write (`io_aux`=0) stores `io_wdata[2:0]` as the tap code of channel B when `io_wdata[3]`=1, and of channel A when it is 0. The other channel's code and rate are unchanged.
- R4: Tap code k selects divider stage 2k, with stage s toggling every 2^s cycles. Assume the divider was halted and an auxiliary write unmasks the channel at clock edge E. The first request is then high in the cycle after edge E+2^(2k), and requests repeat every 2^(2k+1) cycles.
- R5: Each request is high for exactly one clock cycle.
- R6: A masked channel raises no request from the cycle after the mask is written. A channel that is still unmasked keeps its rate.
- R7: While both channels are masked, the divider is cleared. A later unmask restarts the timing of R4 from zero, whatever count was reached before.
- R8: An auxiliary write (`io_aux`=1) sets the following bits, with a mask bit of 1 meaning masked. The new level values appear on `lvl_a`/`lvl_b` in the cycle after the write edge.
  - bit 0: mask A
  - bit 1: mask B
  - bit 2: level A
  - bit 3: level B

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | subsystem clock |
| rst | input | 1 | synchronous active-high reset |
| io_we | input | 1 | bus write strobe |
| io_aux | input | 1 | 0 selects the primary register, 1 the auxiliary register |
| io_addr | input | 4 | bus address |
| io_wdata | input | 4 | bus write data |
| irq_a | output | 1 | channel A request pulse |
| irq_b | output | 1 | channel B request pulse |
| lvl_a | output | 1 | channel A priority level |
| lvl_b | output | 1 | channel B priority level |

## Verification
Most internal faults show up as a change in request timing.
- **Wrong tap decode or divider count:** the first pulse after an unmask moves away from 2^(2k) cycles, or the spacing between pulses is wrong. With small codes this is visible within a handful of cycles.
- **Clear not applied while both channels are masked:** the first pulse after a re-unmask comes early.
- **Buffer written for the wrong channel:** the other channel's rate changes on its next measurement.
- **Mask or level stored wrongly:** this appears one cycle after the auxiliary write, either as a stray pulse or as a wrong level output.

// File: rtl/tick_prescaler_pkg.sv
package tick_prescaler_pkg;
  localparam int CHANNELS = 2;
  localparam int CH_A     = 0;
  localparam int CH_B     = 1;
  localparam logic [3:0] AUX_RESET = 4'b0011;
endpackage

// File: rtl/tp_regs.sv
module tp_regs #(
  parameter int ADDR_W = 4,
  parameter int CODE_W = 3,
  parameter logic [ADDR_W-1:0] BASE = '1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  io_we,
  input  logic                                  io_aux,
  input  logic [ADDR_W-1:0]                     io_addr,
  input  logic [CODE_W:0]                       io_wdata,
  output logic [tick_prescaler_pkg::CHANNELS-1:0][CODE_W-1:0] code,
  output logic [tick_prescaler_pkg::CHANNELS-1:0] masked,
  output logic [tick_prescaler_pkg::CHANNELS-1:0] level
);
  import tick_prescaler_pkg::*;

  logic hit, wr_pri, wr_aux;
  assign hit    = io_we && (io_addr == BASE);
  assign wr_pri = hit && !io_aux;
  assign wr_aux = hit && io_aux;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        code[ch]   <= '0;
        masked[ch] <= AUX_RESET[ch];
        level[ch]  <= AUX_RESET[CHANNELS+ch];
      end else begin
        if (wr_pri && (io_wdata[CODE_W] == (ch == CH_B)))
          code[ch] <= io_wdata[CODE_W-1:0];
        if (wr_aux) begin
          masked[ch] <= io_wdata[ch];
          level[ch]  <= io_wdata[CHANNELS+ch];
        end
      end
    end
  end

  // R3: a code write aimed at channel A leaves channel B's buffer untouched
  assert_b_code_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_pri && !io_wdata[CODE_W]) |=> $stable(code[CH_B]));

  // R2: writes elsewhere leave masks and levels alone
  assert_foreign_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(masked) && $stable(level)));
endmodule

// File: rtl/tp_divider.sv
module tp_divider #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rise
);
  // rise[s] = stage s goes 0 -> 1 on the coming edge
  for (genvar s = 0; s < W; s++) begin : g_rise
    if (s == 0) begin : g_lsb
      assign rise[s] = run && !cnt[0];
    end else begin : g_upper
      assign rise[s] = run && (&cnt[s-1:0]) && !cnt[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + W'(1);
  end

  // R7: a halted divider sits at zero
  assert_halt_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

  // R4: a running divider advances by exactly one
  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    run |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/tp_tap.sv
module tp_tap #(
  parameter int W      = 15,
  parameter int CODE_W = 3,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      rise,
  input  logic [CODE_W-1:0] code,
  input  logic              masked,
  output logic              irq
);
  localparam int IDX_W = $clog2(W);

  logic [IDX_W-1:0] idx;
  assign idx = IDX_W'(int'(code) * STEP);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= rise[idx] && !masked;
  end

  // R6: no request in the cycle after the channel was masked
  assert_masked_silent_R6: assert property (@(posedge clk) disable iff (rst)
    masked |=> !irq);
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int ADDR_W = 4,
  parameter int CODE_W = 3,
  parameter int DIV_W  = 15,
  parameter logic [ADDR_W-1:0] BASE = 4'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_we,
  input  logic              io_aux,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [CODE_W:0]   io_wdata,
  output logic              irq_a,
  output logic              irq_b,
  output logic              lvl_a,
  output logic              lvl_b
);
  import tick_prescaler_pkg::*;

  localparam int TAPS = 2 ** CODE_W;
  localparam int STEP = (DIV_W - 1) / (TAPS - 1);

  logic [CHANNELS-1:0][CODE_W-1:0] code;
  logic [CHANNELS-1:0]             masked, level, irq;
  logic [DIV_W-1:0]                cnt, rise;
  logic                            run;

  tp_regs #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst(rst), .io_we(io_we), .io_aux(io_aux),
    .io_addr(io_addr), .io_wdata(io_wdata),
    .code(code), .masked(masked), .level(level)
  );

  assign run = !(&masked);

  tp_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(run), .cnt(cnt), .rise(rise)
  );

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_tap
    tp_tap #(.W(DIV_W), .CODE_W(CODE_W), .STEP(STEP)) u_tap (
      .clk(clk), .rst(rst), .rise(rise), .code(code[ch]),
      .masked(masked[ch]), .irq(irq[ch])
    );
  end

  assign irq_a = irq[CH_A];
  assign irq_b = irq[CH_B];
  assign lvl_a = level[CH_A];
  assign lvl_b = level[CH_B];

  // R5: a request never lasts two cycles while the tap code holds
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_a && $stable(code[CH_A])) |=> !irq_a);

  // R1: both masked means both request lines stay low
  assert_halt_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (&masked) |=> (!irq_a && !irq_b));
endmodule

// File: tb/tick_prescaler_tb.sv
module tick_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       io_we, io_aux;
  logic [3:0] io_addr, io_wdata;
  logic       irq_a, irq_b, lvl_a, lvl_b;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tick_prescaler u_dut (
    .clk(clk), .rst(rst), .io_we(io_we), .io_aux(io_aux),
    .io_addr(io_addr), .io_wdata(io_wdata),
    .irq_a(irq_a), .irq_b(irq_b), .lvl_a(lvl_a), .lvl_b(lvl_b)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input bit aux, input logic [3:0] addr, input logic [3:0] data);
    @(negedge clk);
    io_we = 1'b1; io_aux = aux; io_addr = addr; io_wdata = data;
    @(posedge clk);
    @(negedge clk);
    io_we = 1'b0;
  endtask

  function automatic logic pick(input bit ch);
    return ch ? irq_b : irq_a;
  endfunction

  // call right after the unmasking write; counts cycles after its edge
  task automatic chk_rate(input bit ch, input int first, input int period, input string req);
    int seen1 = -1;
    int seen2 = -1;
    bit after = 1'b0;
    int lim = first + period + 2;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (pick(ch)) begin
        if (seen1 < 0) seen1 = k;
        else if (seen2 < 0 && k > first + 1) seen2 = k;
      end
      if (k == first + 1) after = pick(ch);
    end
    chk(seen1 == first, req, "first request cycle", seen1, first);
    chk(!after, "R5", "request width", int'(after), 0);
    if (period > 0)
      chk(seen2 - seen1 == period, req, "request period", seen2 - seen1, period);
  endtask

  task automatic t_reset();
    int cnt = 0;
    chk(!irq_a && !irq_b, "R1", "irq after reset", int'(irq_a | irq_b), 0);
    chk(!lvl_a && !lvl_b, "R1", "level after reset", int'(lvl_a | lvl_b), 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cnt += int'(irq_a) + int'(irq_b);
    end
    chk(cnt == 0, "R1", "requests while masked", cnt, 0);
  endtask

  task automatic t_rates();
    bus_wr(0, 4'hF, 4'b0000);
    bus_wr(1, 4'hF, 4'b0010);
    chk_rate(0, 1, 2, "R4");
    bus_wr(1, 4'hF, 4'b0011);
    bus_wr(0, 4'hF, 4'b0011);
    bus_wr(1, 4'hF, 4'b0010);
    chk_rate(0, 64, 128, "R4");
    bus_wr(1, 4'hF, 4'b0011);
    bus_wr(0, 4'hF, 4'b0111);
    bus_wr(1, 4'hF, 4'b0010);
    chk_rate(0, 16384, 0, "R4");
    bus_wr(1, 4'hF, 4'b0011);
  endtask

  task automatic t_independent();
    bus_wr(0, 4'hF, 4'b0001);
    bus_wr(0, 4'hF, 4'b1010);
    bus_wr(1, 4'hF, 4'b0010);
    chk_rate(0, 4, 8, "R3");
    bus_wr(1, 4'hF, 4'b0011);
    bus_wr(1, 4'hF, 4'b0001);
    chk_rate(1, 16, 32, "R3");
    bus_wr(1, 4'hF, 4'b0011);
  endtask

  task automatic t_foreign();
    int cnt = 0;
    bus_wr(0, 4'hE, 4'b0011);
    bus_wr(1, 4'hE, 4'b1100);
    chk(!lvl_a && !lvl_b, "R2", "levels after foreign write", int'(lvl_a | lvl_b), 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cnt += int'(irq_a) + int'(irq_b);
    end
    chk(cnt == 0, "R2", "requests after foreign unmask", cnt, 0);
    bus_wr(1, 4'hF, 4'b0010);
    chk_rate(0, 4, 8, "R2");
    bus_wr(1, 4'hF, 4'b0011);
  endtask

  task automatic t_mask_one();
    int ca = 0;
    int cb = 0;
    bus_wr(0, 4'hF, 4'b0000);
    bus_wr(0, 4'hF, 4'b1000);
    bus_wr(1, 4'hF, 4'b0000);
    repeat (6) @(negedge clk);
    bus_wr(1, 4'hF, 4'b0001);
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      ca += int'(irq_a);
      cb += int'(irq_b);
    end
    chk(ca == 0, "R6", "masked channel requests", ca, 0);
    chk(cb == 10, "R6", "other channel requests", cb, 10);
    bus_wr(1, 4'hF, 4'b0011);
  endtask

  task automatic t_restart();
    bus_wr(0, 4'hF, 4'b0010);
    bus_wr(1, 4'hF, 4'b0010);
    repeat (21) @(negedge clk);
    bus_wr(1, 4'hF, 4'b0011);
    repeat (3) @(negedge clk);
    bus_wr(1, 4'hF, 4'b0010);
    chk_rate(0, 16, 32, "R7");
    bus_wr(1, 4'hF, 4'b0011);
  endtask

  task automatic t_levels();
    bus_wr(1, 4'hF, 4'b0111);
    chk(lvl_a && !lvl_b, "R8", "levels 01", {30'd0, lvl_b, lvl_a}, 1);
    bus_wr(1, 4'hF, 4'b1011);
    chk(!lvl_a && lvl_b, "R8", "levels 10", {30'd0, lvl_b, lvl_a}, 2);
    bus_wr(0, 4'hF, 4'b0000);
    bus_wr(1, 4'hF, 4'b1101);
    chk(lvl_a && lvl_b, "R8", "levels 11", {30'd0, lvl_b, lvl_a}, 3);
    chk_rate(1, 1, 2, "R8");
    bus_wr(1, 4'hF, 4'b0011);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; io_we = 1'b0; io_aux = 1'b0; io_addr = '0; io_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rates();
    t_independent();
    t_foreign();
    t_mask_one();
    t_restart();
    t_levels();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule